// File: doc/BRIEF.md
# Banked Enhanced UART Register Front End

This block is the byte-wide register decode for a 16550-style serial port. It takes a 3-bit offset with read and write strobes. It holds the line-control byte. When that byte equals a key value, it opens an enhanced window that reaches registers a plain UART does not have.

Inside the window, offset 2 becomes a feature register. Its top two bits choose which bank of extra registers appears at offsets 4 through 7. The storage banks hold the flow-control characters, the receive and transmit thresholds, an enumeration byte and two auxiliary bytes. A fixed hardware identifier is readable from one bank slot.

Every stored value is driven out on its own port for the flow-control and FIFO logic. Accesses that belong to the ordinary UART datapath are flagged so that logic can take them.

Top module: `uart_bank_regs`

## Requirements
- R1: Offset 3 is the line-control register in every mode. A write stores the byte, a read returns it, and it is driven on `lcr_o`.
- R2: The enhanced window is open only while the line-control byte equals KEY (default 0xBF). In the window, offset 2 is the feature register and reads back all 8 stored bits. Outside the window, writes to offsets 0, 1, 2 and 4–7 change no enhanced register.
- R3: Feature bits [7:6] select bank 0 to 3, bit 4 drives `enh_en_o`, and bits [3:0] drive `flow_ctl_o`.
- R4: In bank 0, offsets 4, 5, 6 and 7 hold the first on-character, second on-character, first off-character and second off-character. These drive `xon1_o`, `xon2_o`, `xoff1_o` and `xoff2_o`.
- R5: In bank 1, offsets 4, 5, 6 and 7 hold the receive low-water level, the receive high-water level, the receive interrupt trigger level and the transmit threshold. These drive `rx_low_o`, `rx_high_o`, `rx_trig_o` and `tx_thr_o`.
- R6: In bank 2, offset 4 is the writable enumeration byte (`enum_o`). Offsets 6 and 7 are writable auxiliary bytes (`aux0_o`, `aux1_o`).
- R7: In bank 2, offset 5 always reads HW_ID (default 0x01), and writes to it are ignored.
- R8: In bank 3, offsets 4–7 read 0x00, and writes there change no register.
- R9: After reset, the line-control byte, the feature register and every stored bank byte are zero.
- R10: `rdata_o` is combinational from the offset, the window state and the bank. It is 0x00 while `rd_i` is low and for offsets owned by the normal datapath.
- R11: `uart_acc_o` is high during a read or write that belongs to the normal datapath, and low otherwise. Outside the window this is every offset except 3. Inside the window it is offsets 0 and 1.
- R12: A write takes effect at the clock edge where `wr_i` is high. A read in the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| uart_acc_o | output | 1 | Access belongs to the normal UART datapath |
| lcr_o | output | 8 | Line-control byte |
| enh_en_o | output | 1 | Enhanced-mode enable bit |
| flow_ctl_o | output | 4 | Software flow-control setting |
| xon1_o | output | 8 | First on-character |
| xon2_o | output | 8 | Second on-character |
| xoff1_o | output | 8 | First off-character |
| xoff2_o | output | 8 | Second off-character |
| rx_low_o | output | 8 | Receive low-water level |
| rx_high_o | output | 8 | Receive high-water level |
| rx_trig_o | output | 8 | Receive interrupt trigger level |
| tx_thr_o | output | 8 | Transmit threshold |
| enum_o | output | 8 | Enumeration byte |
| aux0_o | output | 8 | Bank 2 auxiliary byte at offset 6 |
| aux1_o | output | 8 | Bank 2 auxiliary byte at offset 7 |

## Verification
A wrong window flag or bank select shows up at once, on the same cycle, as a wrong `rdata_o` or `uart_acc_o` during a read. A write steered to the wrong slot shows one cycle later on the dedicated output port of the slot that was hit. The bench writes a distinct byte to every bank and slot, then reads each one back and checks every output port. It then leaves the window and writes all offsets, to catch stores that leak through the key gate.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;
  localparam int AW     = 3;
  localparam int BANK_W = 2;
  localparam int SLOT_W = 2;
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int NBANK  = 3;             // banks with storage; bank 3 is empty
  localparam int NREG   = NBANK * SLOTS;
  localparam int ID_BANK = 2;
  localparam int ID_SLOT = 1;
  localparam logic [AW-1:0] OFF_FEAT = 3'd2;
  localparam logic [AW-1:0] OFF_LCR  = 3'd3;

  typedef struct packed {
    logic sel_lcr;
    logic sel_feat;
    logic sel_bank;
    logic uart_acc;
  } dec_t;
endpackage

// File: rtl/uart_bank_decode.sv
module uart_bank_decode
  import uart_bank_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          win_i,
  output dec_t          dec_o
);
  always_comb begin
    dec_o.sel_lcr  = (addr_i == OFF_LCR);
    dec_o.sel_feat = win_i && (addr_i == OFF_FEAT);
    dec_o.sel_bank = win_i && addr_i[AW-1];
    dec_o.uart_acc = (wr_i || rd_i) &&
                     !(dec_o.sel_lcr || dec_o.sel_feat || dec_o.sel_bank);
  end
endmodule

// File: rtl/uart_bank_file.sv
module uart_bank_file
  import uart_bank_pkg::*;
#(
  parameter int          DW    = 8,
  parameter logic [DW-1:0] HW_ID = 8'h01
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [BANK_W-1:0]          bank_i,
  input  logic [SLOT_W-1:0]          slot_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [NREG-1:0][DW-1:0]    regs_o,
  output logic [DW-1:0]              rdata_o
);
  localparam int IW = BANK_W + SLOT_W;

  logic [DW-1:0] mem_q [NREG];
  logic [IW-1:0] idx;

  assign idx = {bank_i, slot_i};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam int IDX = b * SLOTS + s;
      if (b == ID_BANK && s == ID_SLOT) begin : g_id
        assign mem_q[IDX] = HW_ID;
      end else begin : g_store
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) mem_q[IDX] <= '0;
          else if (wr_i && idx == IW'(IDX)) mem_q[IDX] <= wdata_i;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++) begin
      regs_o[i] = mem_q[i];
      if (idx == IW'(i)) rdata_o = mem_q[i];
    end
  end

  AST_EMPTY_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && bank_i == BANK_W'(NBANK)) |=> $stable(regs_o)); // R8
endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import uart_bank_pkg::*;
#(
  parameter int            DW    = 8,
  parameter logic [DW-1:0] KEY   = 8'hBF,
  parameter logic [DW-1:0] HW_ID = 8'h01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          uart_acc_o,
  output logic [DW-1:0] lcr_o,
  output logic          enh_en_o,
  output logic [3:0]    flow_ctl_o,
  output logic [DW-1:0] xon1_o,
  output logic [DW-1:0] xon2_o,
  output logic [DW-1:0] xoff1_o,
  output logic [DW-1:0] xoff2_o,
  output logic [DW-1:0] rx_low_o,
  output logic [DW-1:0] rx_high_o,
  output logic [DW-1:0] rx_trig_o,
  output logic [DW-1:0] tx_thr_o,
  output logic [DW-1:0] enum_o,
  output logic [DW-1:0] aux0_o,
  output logic [DW-1:0] aux1_o
);
  logic [DW-1:0] lcr_q, feat_q, bank_rdata;
  logic [NREG-1:0][DW-1:0] regs;
  logic win;
  dec_t dec;

  assign win = (lcr_q == KEY);

  uart_bank_decode u_dec (
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .rd_i   (rd_i),
    .win_i  (win),
    .dec_o  (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q  <= '0;
      feat_q <= '0;
    end else if (wr_i) begin
      if (dec.sel_lcr)  lcr_q  <= wdata_i;
      if (dec.sel_feat) feat_q <= wdata_i;
    end
  end

  uart_bank_file #(.DW(DW), .HW_ID(HW_ID)) u_file (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i && dec.sel_bank),
    .bank_i  (feat_q[DW-1 -: BANK_W]),
    .slot_i  (addr_i[SLOT_W-1:0]),
    .wdata_i (wdata_i),
    .regs_o  (regs),
    .rdata_o (bank_rdata)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (dec.sel_lcr)       rdata_o = lcr_q;
      else if (dec.sel_feat) rdata_o = feat_q;
      else if (dec.sel_bank) rdata_o = bank_rdata;
    end
  end

  assign uart_acc_o = dec.uart_acc;
  assign lcr_o      = lcr_q;
  assign enh_en_o   = feat_q[4];
  assign flow_ctl_o = feat_q[3:0];
  assign xon1_o     = regs[0];
  assign xon2_o     = regs[1];
  assign xoff1_o    = regs[2];
  assign xoff2_o    = regs[3];
  assign rx_low_o   = regs[4];
  assign rx_high_o  = regs[5];
  assign rx_trig_o  = regs[6];
  assign tx_thr_o   = regs[7];
  assign enum_o     = regs[8];
  assign aux0_o     = regs[10];
  assign aux1_o     = regs[11];

  AST_LCR_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_LCR) |=> (lcr_o == $past(wdata_i))); // R1
  AST_FEAT_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && lcr_o == KEY && addr_i == OFF_FEAT) |=> ({feat_q[7:6], enh_en_o, flow_ctl_o} == {$past(wdata_i[7:6]), $past(wdata_i[4:0])})); // R3
  AST_CLOSED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && lcr_o != KEY && addr_i != OFF_LCR) |=> ($stable(feat_q) && $stable(regs))); // R2
  AST_ID_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && lcr_o == KEY && feat_q[7:6] == 2'd2 && addr_i == 3'd5) |-> (rdata_o == HW_ID)); // R7
  AST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i) |-> (rdata_o == '0)); // R10
endmodule

// File: tb/uart_bank_regs_tb.sv
module uart_bank_regs_tb_top;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic wr = 0, rd = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, lcr, xon1, xon2, xoff1, xoff2, rxl, rxh, rxt, txt, enm, aux0, aux1;
  logic uacc, enh;
  logic [3:0] fc;
  int n_chk = 0, n_err = 0;
  logic [7:0] exp_m [4][4];

  always #5 clk = ~clk;

  uart_bank_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .uart_acc_o(uacc), .lcr_o(lcr), .enh_en_o(enh), .flow_ctl_o(fc),
    .xon1_o(xon1), .xon2_o(xon2), .xoff1_o(xoff1), .xoff2_o(xoff2),
    .rx_low_o(rxl), .rx_high_o(rxh), .rx_trig_o(rxt), .tx_thr_o(txt),
    .enum_o(enm), .aux0_o(aux0), .aux1_o(aux1)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d, input logic exp_acc);
    @(negedge clk);
    addr = a; wdata = d; wr = 1;
    #1 chk("R11 write acc", {7'd0, uacc}, {7'd0, exp_acc});
    @(negedge clk);
    wr = 0;
  endtask

  task automatic do_rd(input logic [2:0] a, output logic [7:0] d, output logic acc);
    @(negedge clk);
    addr = a; rd = 1;
    #1 d = rdata; acc = uacc;
    @(negedge clk);
    rd = 0;
  endtask

  function automatic logic [7:0] pat(input int b, input int s);
    return 8'((b * 37 + s * 11) ^ 8'h5A);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic acc;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 lcr", lcr, 8'h00);
    chk("R9 xon1", xon1, 8'h00);
    chk("R9 aux1", aux1, 8'h00);
    chk("R9 flow", {3'd0, enh, fc}, 8'h00);
    chk("R10 idle rdata", rdata, 8'h00);
    rst_n = 1;
    for (int b = 0; b < 4; b++)
      for (int s = 0; s < 4; s++)
        exp_m[b][s] = (b == 2 && s == 1) ? 8'h01 : 8'h00;

    // R1 LCR write/read, window closed; R11 normal-mode access flag
    do_wr(3'd3, 8'h03, 1'b0);
    do_rd(3'd3, d, acc);
    chk("R1 lcr rd", d, 8'h03);
    chk("R1 lcr port", lcr, 8'h03);
    do_rd(3'd5, d, acc);
    chk("R10 closed rd", d, 8'h00);
    chk("R11 closed acc", {7'd0, acc}, 8'h01);

    // open the window, fill every bank and slot
    do_wr(3'd3, 8'hBF, 1'b0);
    for (int b = 0; b < 4; b++) begin
      do_wr(3'd2, 8'((b << 6) | 8'h10 | b), 1'b0);
      for (int s = 0; s < 4; s++) begin
        do_wr(3'(4 + s), pat(b, s), 1'b0);
        if (b < 3 && !(b == 2 && s == 1)) exp_m[b][s] = pat(b, s);
        // R12: new value visible on the next cycle
        do_rd(3'(4 + s), d, acc);
        chk((b == 3) ? "R8 empty bank" : (b == 2 && s == 1) ? "R7 id" : "R12 readback", d, exp_m[b][s]);
      end
    end

    // sweep read-back of every bank through the feature register
    for (int b = 0; b < 4; b++) begin
      do_wr(3'd2, 8'((b << 6) | 8'h20 | (15 - b)), 1'b0);
      do_rd(3'd2, d, acc);
      chk("R2 feat rd", d, 8'((b << 6) | 8'h20 | (15 - b)));
      chk("R3 flow", {3'd0, enh, fc}, 8'(15 - b));
      for (int s = 0; s < 4; s++) begin
        do_rd(3'(4 + s), d, acc);
        chk(b == 0 ? "R4 bank0" : b == 1 ? "R5 bank1" : b == 2 ? (s == 1 ? "R7 id" : "R6 bank2") : "R8 bank3", d, exp_m[b][s]);
        chk("R11 bank acc", {7'd0, acc}, 8'h00);
      end
    end
    do_rd(3'd0, d, acc);
    chk("R11 window off0 acc", {7'd0, acc}, 8'h01);
    chk("R10 window off0 rd", d, 8'h00);
    do_wr(3'd2, 8'h10, 1'b0);
    chk("R3 enh bit", {7'd0, enh}, 8'h01);

    chk("R4 xon1", xon1, exp_m[0][0]);  chk("R4 xon2", xon2, exp_m[0][1]);
    chk("R4 xoff1", xoff1, exp_m[0][2]); chk("R4 xoff2", xoff2, exp_m[0][3]);
    chk("R5 rxl", rxl, exp_m[1][0]);     chk("R5 rxh", rxh, exp_m[1][1]);
    chk("R5 rxt", rxt, exp_m[1][2]);     chk("R5 txt", txt, exp_m[1][3]);
    chk("R6 enum", enm, exp_m[2][0]);    chk("R6 aux0", aux0, exp_m[2][2]);
    chk("R6 aux1", aux1, exp_m[2][3]);

    // close the window; writes elsewhere must not touch enhanced state
    do_wr(3'd3, 8'hBE, 1'b0);
    for (int a = 0; a < 8; a++)
      if (a != 3) do_wr(3'(a), 8'hFF, 1'b1);
    do_rd(3'd2, d, acc);
    chk("R2 closed feat rd", d, 8'h00);
    chk("R2 flow hold", {3'd0, enh, fc}, 8'h10);
    chk("R2 xon1 hold", xon1, exp_m[0][0]);
    chk("R2 txt hold", txt, exp_m[1][3]);
    chk("R2 aux1 hold", aux1, exp_m[2][3]);
    // reopen: feature and bank 2 intact
    do_wr(3'd3, 8'hBF, 1'b0);
    do_wr(3'd2, 8'h80, 1'b0);
    do_rd(3'd4, d, acc);
    chk("R2 enum intact", d, exp_m[2][0]);
    do_rd(3'd5, d, acc);
    chk("R7 id after writes", d, 8'h01);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule